// File: doc/BRIEF.md
# DRAM Command Spacing Tracker

This block runs alongside a DRAM command scheduler. It watches every command the scheduler issues and, on each DRAM clock, reports whether an activate, a write or a read may legally go out to each rank or rank-bank. Each timing rule has its own scope, either a whole rank or a single bank within a rank, and its own programmable gap. Every rule is tracked by a down-counter. A command is allowed only when every counter that gates it has drained to zero, so several overlapping windows combine into each decision. No single fixed timer covers them all.

The gaps are held in two 32-bit configuration words, written and read through a plain register port. The issued-command input carries no back-pressure. The tracker samples `cmd_valid` on every rising edge and always accepts the command, so there is no ready signal. The scheduler is expected to consult the `*_ok` flags before it raises `cmd_valid`. Command codes on `cmd_type` are: 1 = ACT, 2 = PRE (one bank), 3 = PRE-ALL (whole rank), 4 = REF, 5 = WRITE, 6 = READ; 0 and 7 are ignored.

Top module: `dram_gap_tracker`

## Requirements
- R1: Configuration word 0 holds the ACT-to-ACT gap in bits 3:0, the PRE-to-ACT gap in bits 7:4, the PRE-ALL-to-ACT gap in bits 11:8 and the REF-to-ACT gap in bits 24:16. Word 1 holds the ACT-to-WRITE gap in bits 3:0, the WRITE-to-WRITE gap in bits 7:4 and the WRITE-to-READ gap in bits 11:8. All other bits read as zero and ignore writes. `cfg_rdata` shows the word selected by `cfg_addr`.
- R2: After reset every gap field reads zero and every `act_ok`, `wr_ok` and `rd_ok` bit is 1.
- R3: A gap of N (N ≥ 1) means the dependent command may issue no earlier than N clocks after the earlier command. Gaps 0 and 1 both allow the dependent command on the very next clock.
- R4: An ACT to a rank blocks ACT to every bank of that same rank for the ACT-to-ACT gap.
- R5: A PRE blocks ACT only to its own rank-bank, for the PRE-to-ACT gap. A PRE-ALL blocks ACT to every bank of its rank, for the PRE-ALL-to-ACT gap.
- R6: A REF blocks ACT to every bank of its rank for the 9-bit REF-to-ACT gap, which allows gaps up to 511.
- R7: An ACT blocks WRITE to its own rank-bank for the ACT-to-WRITE gap.
- R8: A WRITE blocks WRITE to every bank of its rank for the WRITE-to-WRITE gap, and blocks READ to that rank for the WRITE-to-READ gap.
- R9: When several windows gate a command, the command is allowed only once all of them have expired. A new load into a counter that is already running never shortens the time left on it.
- R10: A change to a gap field affects only counters loaded after the write. A window that is already running keeps its original length.
- R11: Commands to one rank never affect the flags of another rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Configuration word select (0 or 1) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Selected configuration word |
| cmd_valid | input | 1 | A command issued this clock |
| cmd_type | input | 3 | Command code |
| cmd_rank | input | 1 | Target rank |
| cmd_bank | input | 3 | Target bank |
| act_ok | output | 16 | ACT allowed, bit rank*8+bank |
| wr_ok | output | 16 | WRITE allowed, bit rank*8+bank |
| rd_ok | output | 2 | READ allowed, bit per rank |

## Verification
A counter that loads the wrong value, loads in the wrong scope or decrements wrongly shows up at the ports as a flag that comes back one or more clocks early or late. A flag that fails to drop on the clock right after the triggering command is also visible, as is one that drops for a bank or rank the command did not address. Every window is measured in clocks from the issuing edge to the first edge on which the flag is high again. That exposes off-by-one errors at gaps 0, 1 and the field maximums. A wrong merge of overlapping loads, or a gap change that leaks into a running count, shows as a window that ends too soon.

// File: rtl/dgt_pkg.sv
`timescale 1ns/1ps
package dgt_pkg;
  localparam int GAP_W = 4;
  localparam int REF_W = 9;

  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_ACT    = 3'd1,
    CMD_PRE    = 3'd2,
    CMD_PREALL = 3'd3,
    CMD_REF    = 3'd4,
    CMD_WR     = 3'd5,
    CMD_RD     = 3'd6
  } cmd_e;

  typedef struct packed {
    logic [REF_W-1:0] ref_act;
    logic [GAP_W-1:0] act_act;
    logic [GAP_W-1:0] pre_act;
    logic [GAP_W-1:0] preall_act;
    logic [GAP_W-1:0] act_wr;
    logic [GAP_W-1:0] wr_wr;
    logic [GAP_W-1:0] wr_rd;
  } gaps_t;
endpackage

// File: rtl/gap_counter.sv
`timescale 1ns/1ps
module gap_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] gap,
  output logic         clear
);
  logic [W-1:0] cnt;
  logic [W-1:0] ld_val;
  logic [W-1:0] dec_val;

  always_comb begin
    ld_val  = (gap == '0) ? '0 : gap - W'(1);
    dec_val = (cnt == '0) ? '0 : cnt - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= (ld_val > dec_val) ? ld_val : dec_val;
    else
      cnt <= dec_val;
  end

  assign clear = (cnt == '0);

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> cnt == $past(cnt) - W'(1));

  // R9
  no_shorten_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cnt > W'(1)) |=> cnt >= $past(cnt) - W'(1));

  // R3
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt == '0) |=> clear);
endmodule

// File: rtl/gap_regs.sv
`timescale 1ns/1ps
module gap_regs
  import dgt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic        addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output gaps_t       gaps
);
  gaps_t g;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g <= '0;
    end else if (we) begin
      if (!addr) begin
        g.act_act    <= wdata[3:0];
        g.pre_act    <= wdata[7:4];
        g.preall_act <= wdata[11:8];
        g.ref_act    <= wdata[24:16];
      end else begin
        g.act_wr <= wdata[3:0];
        g.wr_wr  <= wdata[7:4];
        g.wr_rd  <= wdata[11:8];
      end
    end
  end

  always_comb begin
    if (!addr)
      rdata = {7'b0, g.ref_act, 4'b0, g.preall_act, g.pre_act, g.act_act};
    else
      rdata = {20'b0, g.wr_rd, g.wr_wr, g.act_wr};
  end

  assign gaps = g;

  // R1
  ref_field_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !addr) |=> g.ref_act == $past(wdata[24:16]));

  // R1
  wrd1_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !addr) |=> $stable(g.wr_rd));
endmodule

// File: rtl/rank_tracker.sv
`timescale 1ns/1ps
module rank_tracker
  import dgt_pkg::*;
#(
  parameter int BANKS = 8,
  localparam int BW = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [2:0]       cmd_type,
  input  logic [BW-1:0]    cmd_bank,
  input  gaps_t            gaps,
  output logic [BANKS-1:0] act_ok,
  output logic [BANKS-1:0] wr_ok,
  output logic             rd_ok
);
  logic is_act, is_pre, is_preall, is_ref, is_wr;
  logic aa_clr, ra_clr, ww_clr, wrd_clr;

  always_comb begin
    is_act    = hit && (cmd_type == CMD_ACT);
    is_pre    = hit && (cmd_type == CMD_PRE);
    is_preall = hit && (cmd_type == CMD_PREALL);
    is_ref    = hit && (cmd_type == CMD_REF);
    is_wr     = hit && (cmd_type == CMD_WR);
  end

  gap_counter #(.W(GAP_W)) u_act_act (
    .clk(clk), .rst_n(rst_n), .load(is_act), .gap(gaps.act_act), .clear(aa_clr));
  gap_counter #(.W(REF_W)) u_ref_act (
    .clk(clk), .rst_n(rst_n), .load(is_ref), .gap(gaps.ref_act), .clear(ra_clr));
  gap_counter #(.W(GAP_W)) u_wr_wr (
    .clk(clk), .rst_n(rst_n), .load(is_wr), .gap(gaps.wr_wr), .clear(ww_clr));
  gap_counter #(.W(GAP_W)) u_wr_rd (
    .clk(clk), .rst_n(rst_n), .load(is_wr), .gap(gaps.wr_rd), .clear(wrd_clr));

  assign rd_ok = wrd_clr;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic bank_sel, pa_load, pa_clr, aw_clr;
    logic [GAP_W-1:0] pa_gap;

    always_comb begin
      bank_sel = (cmd_bank == BW'(b));
      pa_load  = (is_pre && bank_sel) || is_preall;
      pa_gap   = is_preall ? gaps.preall_act : gaps.pre_act;
    end

    gap_counter #(.W(GAP_W)) u_pre_act (
      .clk(clk), .rst_n(rst_n), .load(pa_load), .gap(pa_gap), .clear(pa_clr));
    gap_counter #(.W(GAP_W)) u_act_wr (
      .clk(clk), .rst_n(rst_n), .load(is_act && bank_sel), .gap(gaps.act_wr),
      .clear(aw_clr));

    assign act_ok[b] = aa_clr && ra_clr && pa_clr;
    assign wr_ok[b]  = ww_clr && aw_clr;
  end

  // R4
  act_act_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && gaps.act_act > GAP_W'(1)) |=> act_ok == '0);

  // R5
  preall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_preall && gaps.preall_act > GAP_W'(1)) |=> act_ok == '0);

  // R6
  ref_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && gaps.ref_act > REF_W'(1)) |=> act_ok == '0);

  // R8
  wr_rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && gaps.wr_rd > GAP_W'(1)) |=> !rd_ok);

  // R8
  wr_wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && gaps.wr_wr > GAP_W'(1)) |=> wr_ok == '0);
endmodule

// File: rtl/dram_gap_tracker.sv
`timescale 1ns/1ps
module dram_gap_tracker
  import dgt_pkg::*;
#(
  parameter int RANKS = 2,
  parameter int BANKS = 8,
  localparam int RW = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BW = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic                   cfg_addr,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  input  logic                   cmd_valid,
  input  logic [2:0]             cmd_type,
  input  logic [RW-1:0]          cmd_rank,
  input  logic [BW-1:0]          cmd_bank,
  output logic [RANKS*BANKS-1:0] act_ok,
  output logic [RANKS*BANKS-1:0] wr_ok,
  output logic [RANKS-1:0]       rd_ok
);
  gaps_t gaps;

  gap_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .gaps(gaps));

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    logic rank_hit;
    assign rank_hit = cmd_valid && (cmd_rank == RW'(r));

    rank_tracker #(.BANKS(BANKS)) u_rank (
      .clk(clk), .rst_n(rst_n), .hit(rank_hit), .cmd_type(cmd_type),
      .cmd_bank(cmd_bank), .gaps(gaps),
      .act_ok(act_ok[r*BANKS +: BANKS]), .wr_ok(wr_ok[r*BANKS +: BANKS]),
      .rd_ok(rd_ok[r]));

    // R11
    other_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rank_hit && act_ok[r*BANKS +: BANKS] == '1) |=> act_ok[r*BANKS +: BANKS] == '1);
  end
endmodule

// File: tb/sim_dram_gap_tracker.sv
`timescale 1ns/1ps
module sim_dram_gap_tracker;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, cfg_we, cfg_addr, cmd_valid;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [2:0]  cmd_type;
  logic        cmd_rank;
  logic [2:0]  cmd_bank;
  logic [15:0] act_ok, wr_ok;
  logic [1:0]  rd_ok;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  dram_gap_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cmd_valid(cmd_valid),
    .cmd_type(cmd_type), .cmd_rank(cmd_rank), .cmd_bank(cmd_bank),
    .act_ok(act_ok), .wr_ok(wr_ok), .rd_ok(rd_ok));

  // vector: kind[27:24], gap[23:12], rank[11:8], bank[7:0]
  // kinds: 0 ACT>ACT, 1 PRE>ACT, 2 PREALL>ACT, 3 REF>ACT, 4 ACT>WR, 5 WR>WR, 6 WR>RD
  localparam int NV = 16;
  localparam logic [27:0] VEC [NV] = '{
    {4'd0, 12'd0,   4'd0, 8'd0}, {4'd0, 12'd1,   4'd1, 8'd3},
    {4'd0, 12'd15,  4'd0, 8'd7}, {4'd1, 12'd5,   4'd1, 8'd2},
    {4'd1, 12'd15,  4'd0, 8'd4}, {4'd2, 12'd7,   4'd0, 8'd1},
    {4'd2, 12'd1,   4'd1, 8'd6}, {4'd3, 12'd511, 4'd1, 8'd0},
    {4'd3, 12'd37,  4'd0, 8'd5}, {4'd3, 12'd0,   4'd0, 8'd2},
    {4'd4, 12'd9,   4'd1, 8'd7}, {4'd4, 12'd2,   4'd0, 8'd0},
    {4'd5, 12'd6,   4'd0, 8'd3}, {4'd5, 12'd15,  4'd1, 8'd1},
    {4'd6, 12'd4,   4'd1, 8'd5}, {4'd6, 12'd0,   4'd0, 8'd6}
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(logic a, logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(logic [2:0] t, logic r, logic [2:0] b);
    cmd_valid = 1'b1; cmd_type = t; cmd_rank = r; cmd_bank = b;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_type = 3'd0;
  endtask

  function automatic logic flag(int k, int r, int b);
    case (k)
      0: return act_ok[r*8 + (b+1)%8];
      1: return act_ok[r*8 + b];
      2: return act_ok[r*8 + (b+3)%8];
      3: return act_ok[r*8 + (b+2)%8];
      4: return wr_ok[r*8 + b];
      5: return wr_ok[r*8 + (b+1)%8];
      default: return rd_ok[r];
    endcase
  endfunction

  task automatic measure(int k, int r, int b, output int j);
    j = 1;
    while (!flag(k, r, b) && j < 700) begin
      @(negedge clk);
      j++;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int j, f0, f6;
    logic [2:0] prior [7];
    prior = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd1, 3'd5, 3'd5};
    rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    cmd_valid = 0; cmd_type = 0; cmd_rank = 0; cmd_bank = 0;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2 act_ok", int'(act_ok), 16'hFFFF);
    chk("R2 wr_ok", int'(wr_ok), 16'hFFFF);
    chk("R2 rd_ok", int'(rd_ok), 3);
    chk("R2 cfg word0", int'(cfg_rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cfg_addr = 1'b1; #0.1;
    chk("R2 cfg word1", int'(cfg_rdata), 0);

    // R1: reserved bits read zero
    wr_cfg(1'b0, 32'hFFFF_FFFF);
    cfg_addr = 1'b0; #0.1;
    chk("R1 word0 mask", int'(cfg_rdata), 32'h01FF_0FFF);
    @(negedge clk);
    wr_cfg(1'b1, 32'hFFFF_FFFF);
    cfg_addr = 1'b1; #0.1;
    chk("R1 word1 mask", int'(cfg_rdata), 32'h0000_0FFF);
    @(negedge clk);

    // R3..R8: table walk, window length from issuing edge to first legal edge
    for (int i = 0; i < NV; i++) begin
      int k, g, r, b;
      logic [31:0] w;
      k = int'(VEC[i][27:24]); g = int'(VEC[i][23:12]);
      r = int'(VEC[i][11:8]);  b = int'(VEC[i][7:0]);
      case (k)
        0: w = 32'(g);
        1: w = 32'(g) << 4;
        2: w = 32'(g) << 8;
        3: w = 32'(g) << 16;
        4: w = 32'(g);
        5: w = 32'(g) << 4;
        default: w = 32'(g) << 8;
      endcase
      wr_cfg(1'b0, (k < 4) ? w : 32'h0);
      wr_cfg(1'b1, (k >= 4) ? w : 32'h0);
      issue(prior[k], r[0], b[2:0]);
      measure(k, r, b, j);
      chk($sformatf("R3 window kind%0d gap%0d (R4 R5 R6 R7 R8)", k, g), j, (g == 0) ? 1 : g);
    end

    // R11: rank isolation; R4: ACT blocks other bank of same rank
    wr_cfg(1'b1, 32'h0);
    wr_cfg(1'b0, 32'h8);
    issue(3'd1, 1'b0, 3'd0);
    chk("R11 other rank act_ok", int'(act_ok[8]), 1);
    chk("R4 same rank other bank", int'(act_ok[4]), 0);
    repeat (10) @(negedge clk);

    // R5: PRE scope is one bank
    wr_cfg(1'b0, 32'h60);
    issue(3'd2, 1'b1, 3'd2);
    chk("R5 PRE other bank", int'(act_ok[11]), 1);
    chk("R5 PRE own bank", int'(act_ok[10]), 0);
    repeat (10) @(negedge clk);

    // R9: REF 10 then PRE-ALL 4 one clock later: ACT waits for REF window
    wr_cfg(1'b0, (32'd10 << 16) | (32'd4 << 8));
    issue(3'd4, 1'b0, 3'd0);
    issue(3'd3, 1'b0, 3'd0);
    measure(1, 0, 1, j);
    chk("R9 combined REF+PREALL", j, 9);

    // R9: PRE gap 9 then PRE-ALL gap 2 does not shorten bank 6
    wr_cfg(1'b0, (32'd9 << 4) | (32'd2 << 8));
    issue(3'd2, 1'b0, 3'd6);
    issue(3'd3, 1'b0, 3'd0);
    f0 = 0; f6 = 0;
    for (int k = 1; k <= 12; k++) begin
      if (f0 == 0 && act_ok[0]) f0 = k;
      if (f6 == 0 && act_ok[6]) f6 = k;
      @(negedge clk);
    end
    chk("R9 PREALL bank0", f0, 2);
    chk("R9 no shorten bank6", f6, 8);

    // R10: reprogram during running window
    wr_cfg(1'b0, 32'h0);
    wr_cfg(1'b1, 32'd12);
    issue(3'd1, 1'b1, 3'd7);
    wr_cfg(1'b1, 32'd2);
    measure(4, 1, 7, j);
    chk("R10 running window kept", j, 11);
    issue(3'd1, 1'b1, 3'd7);
    measure(4, 1, 7, j);
    chk("R10 new gap on next load", j, 2);

    // R8: READ command itself opens no window
    wr_cfg(1'b1, 32'hF00);
    issue(3'd6, 1'b0, 3'd0);
    chk("R8 READ no effect", int'(rd_ok[0]), 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule